// File: doc/BRIEF.md
# UART Baud Tick Generator with Re-synchronising Receive Timer

This block produces the two bit-rate strobes a UART needs: one for the transmitter and one for the receiver. Both come from an 8-bit up-counter that starts at a programmable reload value, counts to 255, and then loads the reload value again. A selectable count source sets the counter's step rate. Every second wrap of a counter produces a baud strobe that is one system clock wide. The baud rate is therefore `f_count / (256 - reload) / 2`.

The transmit strobe comes from the main counter. The receive strobe comes from a second counter with the same reload value and the same count source. This second counter has no register access. When a start bit is seen on the receive line, the receive counter is loaded with the reload value at once and its divide-by-two stage is cleared. Receive bit timing therefore starts at the start bit, whatever the phase of the transmit counter.

A small state machine qualifies start bits and has two states, `SD_ARMED` and `SD_FRAME`:
- In `SD_ARMED`, a falling edge on the synchronised receive line issues one forced reload and takes the transition *start seen* to `SD_FRAME`.
- In `SD_FRAME`, falling edges are ignored. The transition *frame done* back to `SD_ARMED` happens when the UART pulses `frame_idle`.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `tx_tick` and `rx_tick` are low.
- R2: With `clk_sel` = 0 (system clock) and `tmr_en` high, `tx_tick` repeats every 2*(256-`reload`) clock cycles, and each pulse is exactly one cycle wide.
- R3: `clk_sel` = 1, 2 and 3 step the counters once every 4, 12 and 48 system clocks respectively. The strobe period is multiplied by that factor.
- R4: `clk_sel` = 4 steps the counters once per eight rising edges of `ext_osc`. `clk_sel` = 5 steps them once per rising edge of `ext_cnt`. `clk_sel` = 6 and 7 stop both counters, and no strobe is produced.
- R5: While `tmr_en` is low, both strobes stay low and both counters hold the reload value. With `clk_sel` = 0, the first `tx_tick` comes on the 2*(256-`reload`)-th rising clock edge that samples `tmr_en` high.
- R6: Without a start bit, `rx_tick` has the same period as `tx_tick` for every source and reload value, and each pulse is one cycle wide.
- R7: In `SD_ARMED`, a high-to-low change of `rx_pin` forces a reload of the receive counter. With `clk_sel` = 0, `rx_tick` first goes high on the (2*(256-`reload`)+3)-th rising edge after the change and then repeats at the R2 period.
- R8: In `SD_FRAME`, further falling edges of `rx_pin` do not move the `rx_tick` phase. A one-cycle high pulse on `frame_idle` returns the detector to `SD_ARMED`, and the next falling edge re-synchronises the receive counter as in R7.
- R9: A forced reload of the receive counter does not change the phase or period of `tx_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Count source: 0 sys, 1 sys/4, 2 sys/12, 3 sys/48, 4 ext_osc/8, 5 ext_cnt, 6-7 stopped |
| ext_osc | input | 1 | External oscillator, asynchronous |
| ext_cnt | input | 1 | External count input, asynchronous |
| tmr_en | input | 1 | Run enable for both counters |
| reload | input | 8 | Reload value shared by both counters |
| rx_pin | input | 1 | UART receive line, asynchronous, idles high |
| frame_idle | input | 1 | One-cycle pulse from the UART when a receive frame ends |
| tx_tick | output | 1 | Transmit baud strobe |
| rx_tick | output | 1 | Receive baud strobe |

## Verification
A wrong counter value or a lost toggle state shows up as a strobe period that differs from 2*(256-reload) times the source divisor. This is visible within one or two strobe periods. A detector stuck in `SD_FRAME` or `SD_ARMED` shows up on the first start bit or the first data-bit edge: `rx_tick` arrives at the wrong edge count, at most 2*(256-reload)+3 cycles after the line falls. A receive reload that leaks into the transmit path shifts `tx_tick` in the very next period.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

    typedef enum logic [2:0] {
        SRC_SYS   = 3'd0,
        SRC_DIVA  = 3'd1,
        SRC_DIVB  = 3'd2,
        SRC_DIVC  = 3'd3,
        SRC_XOSC  = 3'd4,
        SRC_EXTIN = 3'd5,
        SRC_OFF6  = 3'd6,
        SRC_OFF7  = 3'd7
    } src_sel_e;

    typedef enum logic {
        SD_ARMED = 1'b0,
        SD_FRAME = 1'b1
    } sd_state_e;

endpackage

// File: rtl/ubg_edge_sync.sv
module ubg_edge_sync #(
    parameter logic IDLE_LEVEL = 1'b0,
    parameter int   STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE_LEVEL}};
            prev  <= IDLE_LEVEL;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/ubg_tick_src.sv
module ubg_tick_src
    import ubg_pkg::*;
#(
    parameter int DIV_A     = 4,
    parameter int DIV_B     = 12,
    parameter int DIV_C     = 48,
    parameter int XOSC_DIV  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    input  logic       xosc_rise,
    input  logic       extin_rise,
    output logic       cnt_en
);
    localparam int PW = $clog2(DIV_C);
    localparam int XW = $clog2(XOSC_DIV);
    localparam int NDIV = 3;

    function automatic int div_of(input int idx);
        if (idx == 0) return DIV_A;
        if (idx == 1) return DIV_B;
        return DIV_C;
    endfunction

    logic [NDIV-1:0] pre_tick;

    for (genvar g = 0; g < NDIV; g++) begin : g_pre
        localparam int D = div_of(g);
        logic [PW-1:0] pcnt;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pcnt        <= '0;
                pre_tick[g] <= 1'b0;
            end else if (pcnt == PW'(D - 1)) begin
                pcnt        <= '0;
                pre_tick[g] <= 1'b1;
            end else begin
                pcnt        <= pcnt + 1'b1;
                pre_tick[g] <= 1'b0;
            end
        end
    end

    logic [XW-1:0] xcnt;
    logic          xosc_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xcnt      <= '0;
            xosc_tick <= 1'b0;
        end else begin
            xosc_tick <= 1'b0;
            if (xosc_rise) begin
                if (xcnt == XW'(XOSC_DIV - 1)) begin
                    xcnt      <= '0;
                    xosc_tick <= 1'b1;
                end else begin
                    xcnt <= xcnt + 1'b1;
                end
            end
        end
    end

    src_sel_e sel;
    assign sel = src_sel_e'(clk_sel);

    always_comb begin
        unique case (sel)
            SRC_SYS:   cnt_en = 1'b1;
            SRC_DIVA:  cnt_en = pre_tick[0];
            SRC_DIVB:  cnt_en = pre_tick[1];
            SRC_DIVC:  cnt_en = pre_tick[2];
            SRC_XOSC:  cnt_en = xosc_tick;
            SRC_EXTIN: cnt_en = extin_rise;
            SRC_OFF6,
            SRC_OFF7:  cnt_en = 1'b0;
            default:   cnt_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/ubg_start_det.sv
module ubg_start_det
    import ubg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_fall,
    input  logic frame_idle,
    output logic start_force
);
    sd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SD_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        start_force = 1'b0;
        unique case (state_q)
            SD_ARMED: begin
                if (line_fall) begin
                    start_force = 1'b1;
                    state_d     = SD_FRAME;
                end
            end
            SD_FRAME: begin
                if (frame_idle) state_d = SD_ARMED;
            end
            default: state_d = SD_ARMED;
        endcase
    end
endmodule

// File: rtl/ubg_reload_timer.sv
module ubg_reload_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cnt_en,
    input  logic         force_load,
    input  logic [W-1:0] reload,
    output logic         baud_tick
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] count;
    logic         half;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= '0;
            half      <= 1'b0;
            baud_tick <= 1'b0;
        end else if (!run || force_load) begin
            count     <= reload;
            half      <= 1'b0;
            baud_tick <= 1'b0;
        end else if (cnt_en) begin
            if (count == TOP) begin
                count     <= reload;
                half      <= ~half;
                baud_tick <= half;
            end else begin
                count     <= count + 1'b1;
                baud_tick <= 1'b0;
            end
        end else begin
            baud_tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int W        = 8,
    parameter int DIV_A    = 4,
    parameter int DIV_B    = 12,
    parameter int DIV_C    = 48,
    parameter int XOSC_DIV = 8,
    parameter int SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   clk_sel,
    input  logic         ext_osc,
    input  logic         ext_cnt,
    input  logic         tmr_en,
    input  logic [W-1:0] reload,
    input  logic         rx_pin,
    input  logic         frame_idle,
    output logic         tx_tick,
    output logic         rx_tick
);
    logic xosc_rise, xosc_fall, xosc_lvl;
    logic extin_rise, extin_fall, extin_lvl;
    logic rx_rise, rx_fall, rx_lvl;
    logic cnt_en;
    logic start_force;

    ubg_edge_sync #(.IDLE_LEVEL(1'b0), .STAGES(SYNC_LEN)) u_sync_xosc (
        .clk(clk), .rst_n(rst_n), .async_in(ext_osc),
        .level(xosc_lvl), .rise(xosc_rise), .fall(xosc_fall)
    );

    ubg_edge_sync #(.IDLE_LEVEL(1'b0), .STAGES(SYNC_LEN)) u_sync_extin (
        .clk(clk), .rst_n(rst_n), .async_in(ext_cnt),
        .level(extin_lvl), .rise(extin_rise), .fall(extin_fall)
    );

    ubg_edge_sync #(.IDLE_LEVEL(1'b1), .STAGES(SYNC_LEN)) u_sync_rx (
        .clk(clk), .rst_n(rst_n), .async_in(rx_pin),
        .level(rx_lvl), .rise(rx_rise), .fall(rx_fall)
    );

    ubg_tick_src #(
        .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .XOSC_DIV(XOSC_DIV)
    ) u_src (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
        .xosc_rise(xosc_rise), .extin_rise(extin_rise), .cnt_en(cnt_en)
    );

    ubg_start_det u_start (
        .clk(clk), .rst_n(rst_n), .line_fall(rx_fall),
        .frame_idle(frame_idle), .start_force(start_force)
    );

    ubg_reload_timer #(.W(W)) u_tx_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_en), .cnt_en(cnt_en),
        .force_load(1'b0), .reload(reload), .baud_tick(tx_tick)
    );

    ubg_reload_timer #(.W(W)) u_rx_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_en), .cnt_en(cnt_en),
        .force_load(start_force), .reload(reload), .baud_tick(rx_tick)
    );
endmodule

// File: rtl/ubg_checker.sv
module ubg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_en,
    input logic [2:0] clk_sel,
    input logic       start_force,
    input logic       tx_tick,
    input logic       rx_tick
);
    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick); // R2

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |=> !rx_tick); // R6

    AST_HALTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!tmr_en) |-> (!tx_tick && !rx_tick)); // R5

    AST_SRC_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clk_sel[2:1] == 2'b11) |-> (!tx_tick && !rx_tick)); // R4

    AST_FORCE_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        start_force |=> !rx_tick); // R7

    AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_force |=> !start_force); // R8
endmodule

bind uart_baud_gen ubg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .clk_sel(clk_sel),
    .start_force(start_force), .tx_tick(tx_tick), .rx_tick(rx_tick)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       ext_osc = 1'b0;
    logic       ext_cnt = 1'b0;
    logic       tmr_en = 1'b0;
    logic [7:0] reload = 8'd0;
    logic       rx_pin = 1'b1;
    logic       frame_idle = 1'b0;
    logic       tx_tick, rx_tick;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    uart_baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_osc(ext_osc),
        .ext_cnt(ext_cnt), .tmr_en(tmr_en), .reload(reload), .rx_pin(rx_pin),
        .frame_idle(frame_idle), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    // external sources: ext_osc rises every 4 cycles, ext_cnt every 6
    int ph_osc = 0;
    int ph_cnt = 0;
    always @(negedge clk) begin
        ph_osc <= (ph_osc == 1) ? 0 : ph_osc + 1;
        if (ph_osc == 1) ext_osc <= ~ext_osc;
        ph_cnt <= (ph_cnt == 2) ? 0 : ph_cnt + 1;
        if (ph_cnt == 2) ext_cnt <= ~ext_cnt;
    end

    // {sel, reload, expected period}
    localparam int NV = 8;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {8'd0, 8'd250, 16'd12},
        {8'd0, 8'd255, 16'd2},
        {8'd0, 8'd0,   16'd512},
        {8'd1, 8'd253, 16'd24},
        {8'd2, 8'd254, 16'd48},
        {8'd3, 8'd255, 16'd96},
        {8'd4, 8'd255, 16'd64},
        {8'd5, 8'd254, 16'd24}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input bit use_rx);
        return use_rx ? rx_tick : tx_tick;
    endfunction

    // caller is at a negedge; returns cycles between two strobes, and width
    task automatic measure(input bit use_rx, output int per, output int wid);
        int guard = 0;
        per = 0;
        wid = 1;
        while (pick(use_rx) == 1'b0 && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        per = 1;
        if (pick(use_rx)) wid = 2;
        while (pick(use_rx) == 1'b0 && per < 6000) begin
            @(negedge clk);
            per++;
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int per, wid;
        int hits;
        string tag;

        // R1: reset
        hits = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (tx_tick || rx_tick) hits++;
        end
        check("R1 reset", hits, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(tx_tick) + int'(rx_tick), 0);

        // table walk: R2, R3, R4, R6
        for (int v = 0; v < NV; v++) begin
            tmr_en  = 1'b0;
            clk_sel = VEC[v][26:24];
            reload  = VEC[v][23:16];
            repeat (3) @(negedge clk);
            tmr_en = 1'b1;
            if (clk_sel == 3'd0) tag = "R2";
            else if (clk_sel <= 3'd3) tag = "R3";
            else tag = "R4";
            measure(1'b0, per, wid);
            check({tag, " tx period"}, per, int'(VEC[v][15:0]));
            check({tag, " tx width"}, wid, 1);
            measure(1'b1, per, wid);
            check("R6 rx period", per, int'(VEC[v][15:0]));
            check("R6 rx width", wid, 1);
        end

        // R4: stopped source
        clk_sel = 3'd6;
        reload  = 8'd255;
        hits = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (tx_tick || rx_tick) hits++;
        end
        check("R4 source off silent", hits, 0);

        // R5: disable holds, then exact first tick
        clk_sel = 3'd0;
        reload  = 8'd0;
        tmr_en  = 1'b0;
        hits = 0;
        for (int k = 0; k < 700; k++) begin
            @(negedge clk);
            if (tx_tick || rx_tick) hits++;
        end
        check("R5 disabled silent", hits, 0);
        reload = 8'd250;
        @(negedge clk);
        tmr_en = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 11) check("R5 no early tick", int'(tx_tick), 0);
            if (k == 12) begin
                check("R5 first tx tick", int'(tx_tick), 1);
                check("R6 rx in step with tx", int'(rx_tick), 1);
            end
        end

        // R7, R8, R9: start bit, ignored data edge, tx phase kept
        repeat (5) @(negedge clk);
        rx_pin = 1'b0;
        hits = 0;
        for (int k = 1; k <= 27; k++) begin
            @(negedge clk);
            if (k == 4) rx_pin = 1'b1;
            if (k == 7) rx_pin = 1'b0;
            if (k == 14) check("R7 no tick before resync", int'(rx_tick), 0);
            if (k == 15) check("R7 first rx tick after start", int'(rx_tick), 1);
            if (k == 22) check("R8 data edge ignored", int'(rx_tick), 0);
            if (k == 27) check("R8 rx phase kept in frame", int'(rx_tick), 1);
            if (tx_tick) hits++;
        end
        check("R9 tx ticks during resync", hits, 2);
        measure(1'b0, per, wid);
        check("R9 tx period after resync", per, 12);

        // R8: falling edge while still in frame is ignored (no re-arm yet)
        rx_pin = 1'b1;
        repeat (4) @(negedge clk);
        rx_pin = 1'b0;
        repeat (3) @(negedge clk);
        rx_pin = 1'b1;
        frame_idle = 1'b1;
        @(negedge clk);
        frame_idle = 1'b0;
        repeat (4) @(negedge clk);
        // re-armed: a new start resynchronises
        rx_pin = 1'b0;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            if (k == 14) check("R8 rearm no early tick", int'(rx_tick), 0);
            if (k == 15) check("R8 rearm resync tick", int'(rx_tick), 1);
        end
        measure(1'b1, per, wid);
        check("R7 rx period after resync", per, 12);

        summary();
        $finish;
    end
endmodule